// File: doc/BRIEF.md
# Two-Channel Step Counter with Direction Decode and Flutter Watch

This block counts events on two clean, already-debounced digital channels. A mode input selects one of four behaviours: off, single (channel 0 only), dual (two independent channels) or quadrature. In quadrature mode the pair of channel levels is decoded as a two-bit Gray sequence. Steps in one direction go to counter 0 and steps in the other go to counter 1, so the net position is the difference of the two counters. Transitions that skip a state are flagged as errors.

Each counter is 24 bits wide, counts upward only and wraps to zero. Each has a programmable threshold that raises a one-cycle flag when the count lands on it. A wrap raises a separate one-cycle flag.

A flutter monitor looks for one channel toggling while the other stays still. Four small counters, one per edge type, each tally the edges of the opposite channel since their own edge last occurred. When one of them reaches four, flutter begins. It ends when the quiet channel moves again. While flutter lasts, quadrature counting can be frozen, or it can temporarily fall back to dual-style counting. A configuration strobe clears all state and restarts the decoder.

Top module: `quad_flutter_counter`

## Requirements
- R1: Both counters increment by at most one per cycle. They wrap from all-ones to zero, and the wrapping increment pulses that counter's overflow flag for one cycle.
- R2: A high `cfg_load` at a clock edge clears both counters, every flag, the direction history, the flutter state and the decoder state (to both channels low). With `mode` = 0 (off), nothing is counted.
- R3: With `mode` = 1 (single), each rising edge of `ch0` increments counter 0 and counter 1 never changes.
- R4: With `mode` = 2 (dual), each rising edge of `ch0` increments counter 0 and each rising edge of `ch1` increments counter 1.
- R5: With `mode` = 3 (quadrature), the decoder state is written {ch1,ch0}. The steps 00→10→11→01→00 increment counter 0, and the reverse steps 00→01→11→10→00 increment counter 1.
- R6: In quadrature counting, a change of both channels in one cycle counts nothing and pulses `qerr` for one cycle. The decoder then takes the new state as its reference.
- R7: Each valid quadrature step shifts its direction into `dir_hist`: bit 0 holds the newest step and bit 1 the one before. A value of 1 means the counter-0 direction.
- R8: In dual or quadrature mode, flutter starts (`flut_start` pulses and `flut_act` rises) on the fourth edge of one channel seen since the last rising edge, or since the last falling edge, of the other channel.
- R9: While flutter is active, any edge on the quiet channel ends it: `flut_end` pulses and `flut_act` falls.
- R10: In quadrature mode with `fl_stop` = 1 and `fl_dual` = 0, no count occurs on any edge that arrives while flutter is active. Counting resumes once flutter has ended.
- R11: In quadrature mode with `fl_dual` = 1, edges that arrive while flutter is active are counted dual-style (rising edges per channel), and `fl_stop` has no effect. Quadrature counting returns after flutter ends.
- R12: When an increment makes a counter equal to its threshold input, that counter's threshold flag pulses for one cycle.
- R13: Every count, flag and history update appears at the first clock edge that samples the causing input levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Configuration strobe that clears all state |
| mode | input | 2 | 0 off, 1 single, 2 dual, 3 quadrature |
| ch0 | input | 1 | Channel 0 level |
| ch1 | input | 1 | Channel 1 level |
| thr0 | input | CNT_W | Threshold for counter 0 |
| thr1 | input | CNT_W | Threshold for counter 1 |
| fl_stop | input | 1 | Freeze quadrature counting during flutter |
| fl_dual | input | 1 | Fall back to dual counting during flutter |
| cnt0 | output | CNT_W | Counter 0 |
| cnt1 | output | CNT_W | Counter 1 |
| dir_hist | output | 2 | Last two step directions |
| qerr | output | 1 | Invalid quadrature transition pulse |
| flut_act | output | 1 | Flutter in progress |
| flut_start | output | 1 | Flutter start pulse |
| flut_end | output | 1 | Flutter end pulse |
| thr_hit0 | output | 1 | Counter 0 reached its threshold |
| thr_hit1 | output | 1 | Counter 1 reached its threshold |
| ovf0 | output | 1 | Counter 0 wrapped |
| ovf1 | output | 1 | Counter 1 wrapped |

## Verification
Every result of this block is due exactly one clock edge after the channel levels that cause it are sampled. This holds for counter updates, error and threshold pulses, overflow, direction history and flutter start/end. The bench changes the channel levels on a falling edge and advances its reference model once for the rising edge that follows. It compares at the next falling edge, so each pulse is seen in its only valid cycle. The directed cases also probe that cycle and its neighbours explicitly: the fourth versus third opposite edge for flutter, step 255 versus 256 for wrap, and the step before the threshold.

// File: rtl/qc_pkg.sv
package qc_pkg;

  typedef enum logic [1:0] {
    QM_OFF    = 2'd0,
    QM_SINGLE = 2'd1,
    QM_DUAL   = 2'd2,
    QM_QUAD   = 2'd3
  } qc_mode_e;

  // Per-cycle channel events relative to the held decoder state
  typedef struct packed {
    logic r0;
    logic f0;
    logic r1;
    logic f1;
    logic ch0;
    logic ch1;
    logic fwd;
    logic rev;
    logic bad;
  } qc_evt_t;

endpackage

// File: rtl/qc_edge_decode.sv
module qc_edge_decode
  import qc_pkg::*;
(
  input  logic [1:0] prv,
  input  logic [1:0] cur,
  output qc_evt_t    ev
);

  always_comb begin
    ev     = '0;
    ev.ch0 = prv[0] ^ cur[0];
    ev.ch1 = prv[1] ^ cur[1];
    ev.r0  = ev.ch0 & cur[0];
    ev.f0  = ev.ch0 & ~cur[0];
    ev.r1  = ev.ch1 & cur[1];
    ev.f1  = ev.ch1 & ~cur[1];
    ev.bad = ev.ch0 & ev.ch1;
    case ({prv, cur})
      4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: ev.fwd = 1'b1;
      4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: ev.rev = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/qc_flutter.sv
module qc_flutter
  import qc_pkg::*;
#(
  parameter int LIM = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    clr,
  input  logic    en,
  input  qc_evt_t ev,
  output logic    act,
  output logic    start,
  output logic    fin
);

  localparam int FW = $clog2(LIM + 1);
  localparam logic [FW-1:0] TOP  = FW'(LIM);
  localparam logic [FW-1:0] LAST = FW'(LIM - 1);

  logic [3:0]    own;
  logic [3:0]    oth;
  logic [3:0]    reach;
  logic [FW-1:0] fc [4];
  logic          quiet;     // 0: channel 0 is the still one
  logic          hit_c0;
  logic          hit_c1;
  logic          quiet_edge;

  // index 0: ch0 rise, 1: ch0 fall, 2: ch1 rise, 3: ch1 fall
  assign own = {ev.f1, ev.r1, ev.f0, ev.r0};
  assign oth = {ev.ch0, ev.ch0, ev.ch1, ev.ch1};

  for (genvar i = 0; i < 4; i++) begin : g_edge
    always_ff @(posedge clk) begin
      if (rst || clr || !en)            fc[i] <= '0;
      else if (own[i])                  fc[i] <= '0;
      else if (oth[i] && fc[i] != TOP)  fc[i] <= fc[i] + 1'b1;
    end
    assign reach[i] = (fc[i] == LAST) && !own[i] && oth[i];
  end

  assign hit_c0     = reach[0] | reach[1];
  assign hit_c1     = reach[2] | reach[3];
  assign quiet_edge = quiet ? ev.ch1 : ev.ch0;

  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      act   <= 1'b0;
      quiet <= 1'b0;
      start <= 1'b0;
      fin   <= 1'b0;
    end else begin
      start <= 1'b0;
      fin   <= 1'b0;
      if (act) begin
        if (quiet_edge) begin
          act <= 1'b0;
          fin <= 1'b1;
        end
      end else if (hit_c0 || hit_c1) begin
        act   <= 1'b1;
        quiet <= !hit_c0;
        start <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/qc_counter.sv
module qc_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] thr,
  output logic [W-1:0] cnt,
  output logic         ovf,
  output logic         hit
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] nxt;
  assign nxt = cnt + W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      ovf <= 1'b0;
      hit <= 1'b0;
    end else begin
      ovf <= inc && (cnt == TOP);
      hit <= inc && (nxt == thr);
      if (inc) cnt <= nxt;
    end
  end

endmodule

// File: rtl/quad_flutter_counter.sv
module quad_flutter_counter
  import qc_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int FLUT_LIM = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [1:0]       mode,
  input  logic             ch0,
  input  logic             ch1,
  input  logic [CNT_W-1:0] thr0,
  input  logic [CNT_W-1:0] thr1,
  input  logic             fl_stop,
  input  logic             fl_dual,
  output logic [CNT_W-1:0] cnt0,
  output logic [CNT_W-1:0] cnt1,
  output logic [1:0]       dir_hist,
  output logic             qerr,
  output logic             flut_act,
  output logic             flut_start,
  output logic             flut_end,
  output logic             thr_hit0,
  output logic             thr_hit1,
  output logic             ovf0,
  output logic             ovf1
);

  localparam int NCH = 2;

  qc_mode_e   md;
  logic [1:0] st_q;
  logic [1:0] cur;
  qc_evt_t    ev;
  logic       is_quad;
  logic       fall_back;
  logic       frozen;
  logic       dual_style;
  logic       quad_live;
  logic       flut_en;
  logic [NCH-1:0]   inc;
  logic [CNT_W-1:0] thr_v [NCH];
  logic [CNT_W-1:0] cnt_v [NCH];
  logic [NCH-1:0]   ovf_v;
  logic [NCH-1:0]   hit_v;

  assign md  = qc_mode_e'(mode);
  assign cur = {ch1, ch0};

  qc_edge_decode u_dec (
    .prv (st_q),
    .cur (cur),
    .ev  (ev)
  );

  assign is_quad    = (md == QM_QUAD);
  assign fall_back  = is_quad && fl_dual && flut_act;
  assign frozen     = is_quad && fl_stop && !fl_dual && flut_act;
  assign dual_style = (md == QM_DUAL) || fall_back;
  assign quad_live  = is_quad && !fall_back;
  assign flut_en    = (md == QM_DUAL) || is_quad;

  always_comb begin
    inc = '0;
    if (!frozen) begin
      inc[0] = ((md == QM_SINGLE) && ev.r0) || (dual_style && ev.r0) ||
               (quad_live && ev.fwd);
      inc[1] = (dual_style && ev.r1) || (quad_live && ev.rev);
    end
  end

  qc_flutter #(.LIM(FLUT_LIM)) u_flut (
    .clk   (clk),
    .rst   (rst),
    .clr   (cfg_load),
    .en    (flut_en),
    .ev    (ev),
    .act   (flut_act),
    .start (flut_start),
    .fin   (flut_end)
  );

  assign thr_v[0] = thr0;
  assign thr_v[1] = thr1;

  for (genvar k = 0; k < NCH; k++) begin : g_cnt
    qc_counter #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (cfg_load),
      .inc (inc[k]),
      .thr (thr_v[k]),
      .cnt (cnt_v[k]),
      .ovf (ovf_v[k]),
      .hit (hit_v[k])
    );
  end

  assign cnt0     = cnt_v[0];
  assign cnt1     = cnt_v[1];
  assign ovf0     = ovf_v[0];
  assign ovf1     = ovf_v[1];
  assign thr_hit0 = hit_v[0];
  assign thr_hit1 = hit_v[1];

  always_ff @(posedge clk) begin
    if (rst || cfg_load) begin
      st_q     <= 2'b00;
      dir_hist <= 2'b00;
      qerr     <= 1'b0;
    end else begin
      st_q <= cur;
      qerr <= quad_live && ev.bad;
      if (quad_live && (ev.fwd || ev.rev))
        dir_hist <= {dir_hist[0], ev.fwd};
    end
  end

endmodule

// File: rtl/qfc_checker.sv
module qfc_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_load,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] thr0,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic             qerr,
  input logic             flut_act,
  input logic             flut_start,
  input logic             flut_end,
  input logic             thr_hit0,
  input logic             ovf0
);

  a_r1_step_le_one: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_load) |-> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + 1'b1));

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    ovf0 |-> (cnt0 == '0));

  a_r2_off_holds: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'd0 && !$past(cfg_load)) |->
      (cnt0 == $past(cnt0) && cnt1 == $past(cnt1)));

  a_r6_err_no_count: assert property (@(posedge clk) disable iff (rst)
    qerr |-> (cnt0 == $past(cnt0) && cnt1 == $past(cnt1)));

  a_r8_start_sets_act: assert property (@(posedge clk) disable iff (rst)
    flut_start |-> flut_act);

  a_r9_end_clears_act: assert property (@(posedge clk) disable iff (rst)
    flut_end |-> (!flut_act && !flut_start));

  a_r12_hit_matches: assert property (@(posedge clk) disable iff (rst)
    thr_hit0 |-> (cnt0 == $past(thr0)));

endmodule

bind quad_flutter_counter qfc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_load   (cfg_load),
  .mode       (mode),
  .thr0       (thr0),
  .cnt0       (cnt0),
  .cnt1       (cnt1),
  .qerr       (qerr),
  .flut_act   (flut_act),
  .flut_start (flut_start),
  .flut_end   (flut_end),
  .thr_hit0   (thr_hit0),
  .ovf0       (ovf0)
);

// File: tb/sim_quad_flutter_counter.sv
module sim_quad_flutter_counter;

  localparam int CW  = 8;
  localparam int MAX = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1, cfg_load = 1'b0;
  logic [1:0] mode = 2'd0;
  logic ch0 = 1'b0, ch1 = 1'b0, fls = 1'b0, fld = 1'b0;
  logic [CW-1:0] thr0 = '0, thr1 = '0;
  logic [CW-1:0] cnt0, cnt1;
  logic [1:0] dh;
  logic qerr, fact, fstart, fend, hit0, hit1, ovf0, ovf1;

  always #4 clk = ~clk;

  quad_flutter_counter #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .mode(mode), .ch0(ch0), .ch1(ch1),
    .thr0(thr0), .thr1(thr1), .fl_stop(fls), .fl_dual(fld),
    .cnt0(cnt0), .cnt1(cnt1), .dir_hist(dh), .qerr(qerr), .flut_act(fact),
    .flut_start(fstart), .flut_end(fend), .thr_hit0(hit0), .thr_hit1(hit1),
    .ovf0(ovf0), .ovf1(ovf1));

  int errs = 0, checks = 0, ncyc = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt0, m_cnt1;
  logic [1:0] m_st, m_dh;
  int m_fc [4];
  bit m_act, m_quiet, m_qerr, m_fs, m_fe, m_ovf0, m_ovf1, m_hit0, m_hit1;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_cnt0 = 0; m_cnt1 = 0; m_st = 2'b00; m_dh = 2'b00;
    for (int i = 0; i < 4; i++) m_fc[i] = 0;
    m_act = 0; m_quiet = 0; m_qerr = 0; m_fs = 0; m_fe = 0;
    m_ovf0 = 0; m_ovf1 = 0; m_hit0 = 0; m_hit1 = 0;
  endtask

  task automatic model_edge();
    logic [1:0] cur, prv;
    bit c0, c1, r0, f0, r1, f1, fw, rv, bad, quad, fb, stp, dst, live, i0, i1, en;
    bit rc0, rc1;
    int own [4];
    int oth [4];
    cur = {ch1, ch0}; prv = m_st;
    c0 = cur[0] ^ prv[0]; c1 = cur[1] ^ prv[1];
    r0 = c0 & cur[0]; f0 = c0 & ~cur[0]; r1 = c1 & cur[1]; f1 = c1 & ~cur[1];
    bad = c0 & c1;
    fw = (prv == 0 && cur == 2) || (prv == 2 && cur == 3) || (prv == 3 && cur == 1) || (prv == 1 && cur == 0);
    rv = (cur == 0 && prv == 2) || (cur == 2 && prv == 3) || (cur == 3 && prv == 1) || (cur == 1 && prv == 0);
    quad = (mode == 3); fb = quad && fld && m_act; stp = quad && fls && !fld && m_act;
    dst = (mode == 2) || fb; live = quad && !fb;
    i0 = !stp && (((mode == 1) && r0) || (dst && r0) || (live && fw));
    i1 = !stp && ((dst && r1) || (live && rv));
    m_ovf0 = i0 && (m_cnt0 == MAX); m_hit0 = i0 && (((m_cnt0 + 1) & MAX) == int'(thr0));
    m_ovf1 = i1 && (m_cnt1 == MAX); m_hit1 = i1 && (((m_cnt1 + 1) & MAX) == int'(thr1));
    if (i0) m_cnt0 = (m_cnt0 + 1) & MAX;
    if (i1) m_cnt1 = (m_cnt1 + 1) & MAX;
    m_qerr = live && bad;
    if (live && (fw || rv)) m_dh = {m_dh[0], fw};
    en = (mode == 2) || quad;
    m_fs = 0; m_fe = 0;
    if (!en) begin
      for (int i = 0; i < 4; i++) m_fc[i] = 0;
      m_act = 0; m_quiet = 0;
    end else begin
      own[0] = r0; own[1] = f0; own[2] = r1; own[3] = f1;
      oth[0] = c1; oth[1] = c1; oth[2] = c0; oth[3] = c0;
      rc0 = (m_fc[0] == 3 && !r0 && c1) || (m_fc[1] == 3 && !f0 && c1);
      rc1 = (m_fc[2] == 3 && !r1 && c0) || (m_fc[3] == 3 && !f1 && c0);
      if (m_act) begin
        if (m_quiet ? c1 : c0) begin m_act = 0; m_fe = 1; end
      end else if (rc0 || rc1) begin
        m_act = 1; m_quiet = !rc0; m_fs = 1;
      end
      for (int i = 0; i < 4; i++) begin
        if (own[i] != 0) m_fc[i] = 0;
        else if (oth[i] != 0 && m_fc[i] < 4) m_fc[i]++;
      end
    end
    m_st = cur;
  endtask

  task automatic compare_all();
    chk("R5 cnt0", cnt0, m_cnt0);
    chk("R5 cnt1", cnt1, m_cnt1);
    chk("R6 qerr", qerr, m_qerr);
    chk("R7 dir_hist", dh, m_dh);
    chk("R8 flut_start", fstart, m_fs);
    chk("R8 flut_act", fact, m_act);
    chk("R9 flut_end", fend, m_fe);
    chk("R1 ovf0", ovf0, m_ovf0);
    chk("R1 ovf1", ovf1, m_ovf1);
    chk("R12 hit0", hit0, m_hit0);
    chk("R12 hit1", hit1, m_hit1);
  endtask

  task automatic cyc(input logic c1, input logic c0);
    ch1 = c1; ch0 = c0;
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_cfg(input logic [1:0] m, input logic s, input logic d,
                        input logic [CW-1:0] t0, input logic [CW-1:0] t1);
    mode = m; fls = s; fld = d; thr0 = t0; thr1 = t1; cfg_load = 1'b1;
    model_clear();
    @(negedge clk);
    cfg_load = 1'b0;
    compare_all();
  endtask

  task automatic summary();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 100000 && !done) begin
      errs++; checks++;
      $display("FAIL R13 watchdog: actual=%0d cycles expected=finish", ncyc);
      summary();
    end
  end

  initial begin
    int base0, base1;
    logic [1:0] seq [4];
    void'($urandom(32'd4242));
    seq[0] = 2'b10; seq[1] = 2'b11; seq[2] = 2'b01; seq[3] = 2'b00;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare_all();
    chk("R2 reset cnt0", cnt0, 0);
    chk("R2 reset flags", {qerr, fact, ovf0, hit0}, 0);

    // R5/R13: forward steps, first result visible one edge later
    do_cfg(2'd3, 0, 0, 8'hFF, 8'hFF);
    cyc(1, 0);
    chk("R13 first step latency", cnt0, 1);
    cyc(1, 1); cyc(0, 1); cyc(0, 0);
    cyc(1, 0); cyc(1, 1); cyc(0, 1); cyc(0, 0);
    chk("R5 fwd total", cnt0, 8);
    chk("R5 no rev", cnt1, 0);
    chk("R7 two fwd", dh, 2'b11);
    cyc(0, 1); cyc(1, 1); cyc(1, 0); cyc(0, 0);
    chk("R5 rev total", cnt1, 4);
    chk("R7 two rev", dh, 2'b00);
    cyc(1, 0); cyc(0, 0);
    chk("R7 fwd then rev", dh, 2'b10);

    // R6: double change
    base0 = cnt0; base1 = cnt1;
    cyc(1, 1);
    chk("R6 err pulse", qerr, 1);
    chk("R6 no count", cnt0 + cnt1, base0 + base1);
    cyc(0, 1);
    chk("R6 err cleared", qerr, 0);
    chk("R6 new reference", cnt0, base0 + 1);
    cyc(0, 0);

    // R12/R1: threshold and wrap
    do_cfg(2'd3, 0, 0, 8'd5, 8'hFF);
    for (int i = 1; i <= 256; i++) begin
      cyc(seq[(i - 1) % 4][1], seq[(i - 1) % 4][0]);
      if (i == 4)   chk("R12 before threshold", hit0, 0);
      if (i == 5)   chk("R12 threshold pulse", hit0, 1);
      if (i == 255) chk("R1 no early wrap", ovf0, 0);
      if (i == 256) begin
        chk("R1 wrap pulse", ovf0, 1);
        chk("R1 wrap value", cnt0, 0);
      end
    end

    // R3: single
    do_cfg(2'd1, 0, 0, 8'hFF, 8'hFF);
    cyc(0, 1); cyc(1, 1); cyc(1, 0); cyc(0, 0); cyc(0, 1); cyc(0, 0); cyc(0, 1);
    chk("R3 ch0 rises", cnt0, 3);
    chk("R3 counter1 idle", cnt1, 0);
    cyc(0, 0);

    // R4: dual
    do_cfg(2'd2, 0, 0, 8'hFF, 8'hFF);
    cyc(0, 1); cyc(0, 0); cyc(0, 1); cyc(1, 1); cyc(0, 1); cyc(1, 1); cyc(0, 1); cyc(1, 1);
    chk("R4 ch0 rises", cnt0, 2);
    chk("R4 ch1 rises", cnt1, 3);
    cyc(0, 0);

    // R8/R9: flutter detection and end
    do_cfg(2'd3, 0, 0, 8'hFF, 8'hFF);
    cyc(1, 0); cyc(0, 0); cyc(1, 0);
    chk("R8 third edge no start", fstart, 0);
    cyc(0, 0);
    chk("R8 fourth edge start", fstart, 1);
    chk("R8 active", fact, 1);
    cyc(0, 1);
    chk("R9 end pulse", fend, 1);
    chk("R9 inactive", fact, 0);
    chk("R5 counts through flutter", cnt1, 3);
    cyc(0, 0);

    // R10: stop during flutter
    do_cfg(2'd3, 1, 0, 8'hFF, 8'hFF);
    cyc(1, 0); cyc(0, 0); cyc(1, 0); cyc(0, 0);
    cyc(1, 0); cyc(0, 0);
    chk("R10 frozen cnt0", cnt0, 2);
    chk("R10 frozen cnt1", cnt1, 2);
    cyc(0, 1);
    chk("R10 end edge not counted", cnt1, 2);
    cyc(0, 0);
    chk("R10 resumes", cnt0, 3);

    // R11: fallback to dual overrides stop
    do_cfg(2'd3, 1, 1, 8'hFF, 8'hFF);
    cyc(1, 0); cyc(0, 0); cyc(1, 0); cyc(0, 0);
    cyc(1, 0);
    chk("R11 dual-style cnt1", cnt1, 3);
    chk("R11 dual-style cnt0", cnt0, 2);
    cyc(0, 0); cyc(0, 1); cyc(0, 0);
    chk("R11 quad restored", cnt0, 4);
    chk("R11 cnt1 final", cnt1, 3);

    // R2: off mode counts nothing
    do_cfg(2'd0, 0, 0, 8'hFF, 8'hFF);
    cyc(0, 1); cyc(1, 1); cyc(1, 0); cyc(0, 0);
    chk("R2 off cnt0", cnt0, 0);
    chk("R2 off cnt1", cnt1, 0);

    // random segments
    for (int seg = 0; seg < 30; seg++) begin
      do_cfg(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
             CW'($urandom % 24), CW'($urandom % 24));
      for (int n = 0; n < 100; n++) begin
        int r;
        logic a, b;
        r = $urandom % 16;
        a = ch1; b = ch0;
        if (r < 6) b = ~b;
        else if (r < 12) a = ~a;
        else if (r == 12) begin a = ~a; b = ~b; end
        cyc(a, b);
      end
    end

    summary();
  end

endmodule